// File: doc/BRIEF.md
# Transport Stream Byte Capture

This block sits between an external cable demodulator and the packet-processing logic. It takes an MPEG2 transport stream and turns it into aligned 188-byte packets. The source is either an 8-bit parallel bus or a single serial line. The block runs on one system clock. The demodulator's byte or bit clock is oversampled as data, so a register bit can choose whether its rising or its falling edge is the one that samples.

A companion strobe marks where each packet starts. A mode bit chooses how that strobe is read. In sync-pulse mode it flags the sync byte itself, or in serial operation only the first bit of that byte. In data-enable mode it is a window that stays high across the 188 payload bytes and drops during the trailing redundancy bytes, which the block throws away. The output is one byte per cycle. Each byte comes with a valid flag, start-of-packet and end-of-packet flags, and a one-cycle realignment error. A lock flag reports whether packets keep arriving with the sync byte 0x47 in front at the expected spacing.

Top module: `ts_capture`

## Requirements
- R1: With `cfg_serial`=0, each active edge of `ts_bclk` captures `ts_data[7:0]` as one byte and presents it unchanged on `out_data`, with bit 7 as the MSB.
- R2: With `cfg_serial`=1, only `ts_data[0]` is used and `ts_data[7:1]` is ignored. Bits are packed MSB first. A byte is emitted after every eighth bit, counted from the bit that the strobe marks as the packet's first bit.
- R3: With `cfg_den`=0 (sync-pulse mode), a sample taken while `ts_strobe` is high marks the first byte of a packet, or the first bit of that byte in serial operation.
- R4: With `cfg_den`=1 (data-enable mode), bytes whose first sample has `ts_strobe` low are discarded and never appear on the output. A low-to-high change of the strobe marks the first byte of a packet.
- R5: With `cfg_fall`=0 the rising edge of `ts_bclk` samples the strobe and data. With `cfg_fall`=1 the falling edge samples them.
- R6: `out_sop` is high with the first byte of each 188-byte packet and `out_eop` is high with byte 188. With no further strobe, the count keeps running packet after packet. Neither flag is ever high without `out_valid`.
- R7: A strobe that marks a packet start while the byte count is mid-packet restarts the count at that byte. That byte carries `out_sop` and a one-cycle `out_err`.
- R8: `out_lock` rises with the start byte of the third consecutive packet that begins with 0x47 at the expected spacing. A realignment restarts that run of packets.
- R9: Once set, `out_lock` falls with the start byte of the second consecutive packet that does not begin with 0x47.
- R10: While `rst_n` is low, all outputs are 0 on the following cycle. After reset, no byte is output until the first strobe-marked packet start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than twice the byte/bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_serial | input | 1 | 0: parallel byte bus, 1: serial input on bit 0 |
| cfg_den | input | 1 | 0: strobe is a sync pulse, 1: strobe is a data-enable window |
| cfg_fall | input | 1 | 0: rising edge of ts_bclk samples, 1: falling edge |
| ts_bclk | input | 1 | Byte or bit clock from the demodulator |
| ts_strobe | input | 1 | Packet-start pulse or data-enable window |
| ts_data | input | 8 | Parallel byte, or serial bit on ts_data[0] |
| out_data | output | 8 | Captured byte |
| out_valid | output | 1 | out_data holds a packet byte this cycle |
| out_sop | output | 1 | First byte of a packet |
| out_eop | output | 1 | Byte 188 of a packet |
| out_err | output | 1 | Mid-packet strobe caused a realignment |
| out_lock | output | 1 | Packet framing is locked |

## Verification
The hardest state to reach is a strobe that lands partway through a packet while the counter is already aligned. The bench first sends a packet cut short after 100 bytes, then a strobe-marked packet. It checks that the restart byte carries both start and error, and that the next end-of-packet lands 188 bytes after the restart, not 188 bytes after the old start. Lock loss needs its own sequence too: three good packets to set lock, then two packets whose first byte is not 0x47. Lock must hold through the first bad start and drop on the second.

// File: rtl/ts_cap_pkg.sv
// Package: shared constants for the transport stream capture block.
// Assumes 188-byte packets led by the sync byte 0x47.
package ts_cap_pkg;
    localparam int          TS_PKT_LEN   = 188;
    localparam logic [7:0]  TS_SYNC_BYTE = 8'h47;
    localparam int          TS_LOCK_GOOD = 3;
    localparam int          TS_LOCK_BAD  = 2;
endpackage

// File: rtl/ts_edge_sync.sv
// Module: ts_edge_sync
// Oversamples the external byte/bit clock, strobe and data on the system
// clock, and emits one sample pulse per active edge of that clock.
// Assumes the system clock runs at more than twice the external clock and
// that data and strobe are stable around the active edge.
module ts_edge_sync #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_fall,
    input  logic          bclk,
    input  logic          strobe,
    input  logic [DW-1:0] data,
    output logic          smp_vld,
    output logic          smp_str,
    output logic [DW-1:0] smp_dat
);
    logic          bclk_q, bclk_q2, str_q;
    logic [DW-1:0] dat_q;
    logic          act_edge;

    // Register the raw inputs together with a delayed copy of the clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q  <= 1'b0;
            bclk_q2 <= 1'b0;
            str_q   <= 1'b0;
            dat_q   <= '0;
        end else begin
            bclk_q  <= bclk;
            bclk_q2 <= bclk_q;
            str_q   <= strobe;
            dat_q   <= data;
        end
    end

    // Detect the edge chosen by the polarity bit.
    always_comb begin
        act_edge = cfg_fall ? (bclk_q2 & ~bclk_q) : (~bclk_q2 & bclk_q);
    end

    // Hold the sample taken at the active edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_vld <= 1'b0;
            smp_str <= 1'b0;
            smp_dat <= '0;
        end else begin
            smp_vld <= act_edge;
            if (act_edge) begin
                smp_str <= str_q;
                smp_dat <= dat_q;
            end
        end
    end
endmodule

// File: rtl/ts_byte_assembler.sv
// Module: ts_byte_assembler
// Turns samples into bytes. In parallel mode every sample is a byte. In
// serial mode bit 0 is shifted in MSB first and a byte is emitted every
// DW bits, counted from the strobe-marked first bit. Each byte carries a
// start mark and an enable taken from the strobe.
// Assumes samples arrive at most every other clock.
module ts_byte_assembler #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_serial,
    input  logic          cfg_den,
    input  logic          smp_vld,
    input  logic          smp_str,
    input  logic [DW-1:0] smp_dat,
    output logic          byt_vld,
    output logic [DW-1:0] byt_dat,
    output logic          byt_start,
    output logic          byt_en
);
    localparam int CW = $clog2(DW);

    logic          str_prev;
    logic          mark;
    logic          smp_en;
    logic [CW-1:0] bit_cnt;
    logic [DW-2:0] shreg;
    logic          pend_start;
    logic          pend_en;

    // Packet-start mark: a strobe level in pulse mode, a rising window in enable mode.
    always_comb begin
        mark   = cfg_den ? (smp_str & ~str_prev) : smp_str;
        smp_en = cfg_den ? smp_str : 1'b1;
    end

    // Keep the previous sampled strobe for window-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)       str_prev <= 1'b0;
        else if (smp_vld) str_prev <= smp_str;
    end

    // Assemble and emit bytes for both input modes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byt_vld    <= 1'b0;
            byt_dat    <= '0;
            byt_start  <= 1'b0;
            byt_en     <= 1'b0;
            bit_cnt    <= '0;
            shreg      <= '0;
            pend_start <= 1'b0;
            pend_en    <= 1'b0;
        end else begin
            byt_vld <= 1'b0;
            if (smp_vld && !cfg_serial) begin
                byt_vld   <= 1'b1;
                byt_dat   <= smp_dat;
                byt_start <= mark;
                byt_en    <= smp_en;
            end else if (smp_vld) begin
                if (mark) begin
                    shreg      <= {{(DW-2){1'b0}}, smp_dat[0]};
                    bit_cnt    <= CW'(1);
                    pend_start <= 1'b1;
                    pend_en    <= smp_en;
                end else if (bit_cnt == CW'(DW-1)) begin
                    byt_vld    <= 1'b1;
                    byt_dat    <= {shreg, smp_dat[0]};
                    byt_start  <= pend_start;
                    byt_en     <= pend_en;
                    bit_cnt    <= '0;
                    pend_start <= 1'b0;
                end else begin
                    if (bit_cnt == '0) pend_en <= smp_en;
                    shreg   <= {shreg[DW-3:0], smp_dat[0]};
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ts_packet_framer.sv
// Module: ts_packet_framer
// Counts bytes into packets, marks start and end of each packet, flags
// mid-packet realignment and tracks sync-byte lock. Bytes with the enable
// low are dropped, and so are bytes seen before the first strobe mark.
// Assumes bytes arrive at most every other clock.
module ts_packet_framer #(
    parameter int          DW        = 8,
    parameter int          PKT_LEN   = 188,
    parameter logic [DW-1:0] SYNC    = 8'h47,
    parameter int          LOCK_GOOD = 3,
    parameter int          LOCK_BAD  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byt_vld,
    input  logic [DW-1:0] byt_dat,
    input  logic          byt_start,
    input  logic          byt_en,
    output logic [DW-1:0] out_data,
    output logic          out_valid,
    output logic          out_sop,
    output logic          out_eop,
    output logic          out_err,
    output logic          out_lock
);
    localparam int IW = $clog2(PKT_LEN);
    localparam int GW = $clog2(LOCK_GOOD + 1);
    localparam int BW = $clog2(LOCK_BAD + 1);

    logic [IW-1:0] idx, pos;
    logic          aligned;
    logic [GW-1:0] good_cnt, g_next;
    logic [BW-1:0] bad_cnt, b_next;
    logic          take, pkt_first, mid, is_sync, last;

    // Decode the current byte's place in the packet and the lock counter updates.
    always_comb begin
        take      = byt_vld & byt_en & (aligned | byt_start);
        pos       = byt_start ? '0 : idx;
        pkt_first = (pos == '0);
        last      = (pos == IW'(PKT_LEN - 1));
        mid       = byt_start & aligned & (idx != '0);
        is_sync   = (byt_dat == SYNC);
        if (mid)
            g_next = GW'(1);
        else if (good_cnt == GW'(LOCK_GOOD))
            g_next = good_cnt;
        else
            g_next = good_cnt + 1'b1;
        b_next = (bad_cnt == BW'(LOCK_BAD)) ? bad_cnt : bad_cnt + 1'b1;
    end

    // Byte output, packet counter and alignment state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_err   <= 1'b0;
            idx       <= '0;
            aligned   <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_err   <= 1'b0;
            if (take) begin
                out_valid <= 1'b1;
                out_data  <= byt_dat;
                out_sop   <= pkt_first;
                out_eop   <= last;
                out_err   <= mid;
                idx       <= last ? '0 : pos + 1'b1;
                aligned   <= 1'b1;
            end
        end
    end

    // Lock tracking on each packet's first byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            good_cnt <= '0;
            bad_cnt  <= '0;
            out_lock <= 1'b0;
        end else if (take && pkt_first) begin
            if (is_sync) begin
                good_cnt <= g_next;
                bad_cnt  <= '0;
                if (g_next == GW'(LOCK_GOOD)) out_lock <= 1'b1;
            end else begin
                good_cnt <= '0;
                bad_cnt  <= b_next;
                if (b_next == BW'(LOCK_BAD)) out_lock <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ts_capture.sv
// Module: ts_capture (top)
// Captures an MPEG2 transport stream from a parallel or serial source.
// The strobe is read as a sync pulse or as a data-enable window, and the
// clock edge is programmable. Delivers framed 188-byte packets with a lock flag.
// Assumes the configuration bits are held steady while traffic flows.
module ts_capture
    import ts_cap_pkg::*;
#(
    parameter int         DW        = 8,
    parameter int         PKT_LEN   = TS_PKT_LEN,
    parameter logic [7:0] SYNC      = TS_SYNC_BYTE,
    parameter int         LOCK_GOOD = TS_LOCK_GOOD,
    parameter int         LOCK_BAD  = TS_LOCK_BAD
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_serial,
    input  logic          cfg_den,
    input  logic          cfg_fall,
    input  logic          ts_bclk,
    input  logic          ts_strobe,
    input  logic [DW-1:0] ts_data,
    output logic [DW-1:0] out_data,
    output logic          out_valid,
    output logic          out_sop,
    output logic          out_eop,
    output logic          out_err,
    output logic          out_lock
);
    logic          smp_vld, smp_str;
    logic [DW-1:0] smp_dat;
    logic          byt_vld, byt_start, byt_en;
    logic [DW-1:0] byt_dat;

    ts_edge_sync #(.DW(DW)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_fall(cfg_fall),
        .bclk    (ts_bclk),
        .strobe  (ts_strobe),
        .data    (ts_data),
        .smp_vld (smp_vld),
        .smp_str (smp_str),
        .smp_dat (smp_dat)
    );

    ts_byte_assembler #(.DW(DW)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_serial(cfg_serial),
        .cfg_den   (cfg_den),
        .smp_vld   (smp_vld),
        .smp_str   (smp_str),
        .smp_dat   (smp_dat),
        .byt_vld   (byt_vld),
        .byt_dat   (byt_dat),
        .byt_start (byt_start),
        .byt_en    (byt_en)
    );

    ts_packet_framer #(
        .DW(DW), .PKT_LEN(PKT_LEN), .SYNC(SYNC[DW-1:0]),
        .LOCK_GOOD(LOCK_GOOD), .LOCK_BAD(LOCK_BAD)
    ) u_frm (
        .clk      (clk),
        .rst_n    (rst_n),
        .byt_vld  (byt_vld),
        .byt_dat  (byt_dat),
        .byt_start(byt_start),
        .byt_en   (byt_en),
        .out_data (out_data),
        .out_valid(out_valid),
        .out_sop  (out_sop),
        .out_eop  (out_eop),
        .out_err  (out_err),
        .out_lock (out_lock)
    );
endmodule

// File: rtl/ts_capture_chk.sv
// Module: ts_capture_chk
// Property checker for ts_capture, attached through bind.
// Assumes the sync byte is 0x47.
module ts_capture_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] out_data,
    input logic       out_valid,
    input logic       out_sop,
    input logic       out_eop,
    input logic       out_err,
    input logic       out_lock
);
    AST_SOP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_sop |-> out_valid);                                   // R6
    AST_EOP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_eop |-> (out_valid && !out_sop));                     // R6
    AST_ERR_AT_SOP: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> out_sop);                                     // R7
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |=> !out_err);                                    // R7
    AST_LOCK_RISE_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_lock) |-> (out_sop && out_data == 8'h47));      // R8
    AST_LOCK_FALL_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_lock) |-> (out_sop && out_data != 8'h47));      // R9
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_lock && !out_err));        // R10
endmodule

bind ts_capture ts_capture_chk u_chk (.*);

// File: tb/sim_ts_capture.sv
module sim_ts_capture;
    localparam int PL  = 188;
    localparam int MAX = 2048;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_serial = 1'b0, cfg_den = 1'b0, cfg_fall = 1'b0;
    logic       ts_bclk = 1'b0, ts_strobe = 1'b0;
    logic [7:0] ts_data = 8'h00;
    logic [7:0] out_data;
    logic       out_valid, out_sop, out_eop, out_err, out_lock;

    int n_chk = 0, n_fail = 0;
    int n_cap = 0, n_exp = 0, pk_seed = 0;
    logic [7:0] exp_dat [MAX];
    logic [7:0] cap_dat [MAX];
    logic       cap_sop [MAX], cap_eop [MAX], cap_lock [MAX], cap_err [MAX];

    // Scenario table: {serial, den, fall, expected final lock, packet count[3:0]}
    localparam logic [7:0] SCN [6] = '{
        {1'b0, 1'b0, 1'b0, 1'b1, 4'd4},
        {1'b0, 1'b1, 1'b0, 1'b1, 4'd4},
        {1'b1, 1'b0, 1'b1, 1'b1, 4'd3},
        {1'b1, 1'b1, 1'b0, 1'b1, 4'd3},
        {1'b0, 1'b0, 1'b1, 1'b0, 4'd2},
        {1'b0, 1'b1, 1'b1, 1'b0, 4'd2}
    };

    always #2 clk = ~clk;

    ts_capture u0 (.*);

    always @(negedge clk) begin
        if (rst_n && out_valid && n_cap < MAX) begin
            cap_dat[n_cap]  = out_data;
            cap_sop[n_cap]  = out_sop;
            cap_eop[n_cap]  = out_eop;
            cap_lock[n_cap] = out_lock;
            cap_err[n_cap]  = out_err;
            n_cap++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_unit(input logic [7:0] d, input logic s);
        @(negedge clk);
        ts_data   = d;
        ts_strobe = s;
        ts_bclk   = cfg_fall;
        repeat (2) @(negedge clk);
        ts_bclk = ~cfg_fall;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] d, input logic s_first, input logic s_rest);
        if (cfg_serial) begin
            for (int b = 7; b >= 0; b--)
                send_unit({7'h55, d[b]}, (b == 7) ? s_first : s_rest);
        end else begin
            send_unit(d, s_first);
        end
    endtask

    task automatic send_packet(input logic [7:0] first, input int len);
        logic [7:0] d;
        for (int i = 0; i < len; i++) begin
            d = (i == 0) ? first : 8'((i * 7 + pk_seed * 13) & 255);
            if (n_exp < MAX) exp_dat[n_exp] = d;
            n_exp++;
            if (cfg_den) send_byte(d, 1'b1, 1'b1);
            else         send_byte(d, i == 0, 1'b0);
        end
        if (cfg_den)
            for (int r = 0; r < 16; r++) send_byte(8'hEE, 1'b0, 1'b0);
        pk_seed++;
    endtask

    task automatic start_run(input logic ser, input logic den, input logic fall);
        @(negedge clk);
        rst_n      = 1'b0;
        cfg_serial = ser;
        cfg_den    = den;
        cfg_fall   = fall;
        ts_strobe  = 1'b0;
        ts_data    = 8'h00;
        repeat (2) @(negedge clk);
        ts_bclk = fall;
        repeat (3) @(negedge clk);
        n_cap = 0;
        n_exp = 0;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int bad;
        int bs, be, er;
        string tag;

        // R10: reset state
        repeat (3) @(negedge clk);
        chk(!out_valid && !out_sop && !out_eop && !out_err && !out_lock,
            "R10 reset outputs", int'({out_valid, out_lock, out_err}), 0);

        // Table walk
        for (int k = 0; k < 6; k++) begin
            logic ser, den, fall, elock;
            int npk;
            {ser, den, fall, elock} = SCN[k][7:4];
            npk = int'(SCN[k][3:0]);
            tag = $sformatf("%s %s %s", ser ? "R2" : "R1", den ? "R4" : "R3",
                            "R5");
            start_run(ser, den, fall);
            for (int p = 0; p < npk; p++) send_packet(8'h47, PL);
            repeat (30) @(negedge clk);
            chk(n_cap == n_exp, {tag, " byte count"}, n_cap, n_exp);
            bad = 0; bs = 0; be = 0; er = 0;
            for (int i = 0; i < n_cap && i < n_exp; i++) begin
                if (cap_dat[i] != exp_dat[i]) bad++;
                if (cap_sop[i] != (i % PL == 0)) bs++;
                if (cap_eop[i] != (i % PL == PL - 1)) be++;
                if (cap_err[i]) er++;
            end
            chk(bad == 0, {tag, " data match"}, bad, 0);
            chk(bs == 0, "R6 sop placement", bs, 0);
            chk(be == 0, "R6 eop placement", be, 0);
            chk(er == 0, "R7 no spurious error", er, 0);
            if (n_cap > 0)
                chk(cap_lock[n_cap-1] == elock, "R8 final lock",
                    int'(cap_lock[n_cap-1]), int'(elock));
            if (npk >= 3 && n_cap > 2 * PL) begin
                chk(cap_lock[2*PL-1] == 1'b0, "R8 lock before third start",
                    int'(cap_lock[2*PL-1]), 0);
                chk(cap_lock[2*PL] == 1'b1, "R8 lock at third start",
                    int'(cap_lock[2*PL]), 1);
            end
        end

        // R10 / R7: bytes before the first strobe dropped; mid-packet realign
        start_run(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) send_byte(8'h47, 1'b0, 1'b0);
        chk(n_cap == 0, "R10 nothing before first strobe", n_cap, 0);
        send_packet(8'h47, 100);
        send_packet(8'h47, PL);
        send_packet(8'h47, PL);
        repeat (30) @(negedge clk);
        chk(n_cap == 100 + 2 * PL, "R7 byte count", n_cap, 100 + 2 * PL);
        er = 0;
        for (int i = 0; i < n_cap; i++) if (cap_err[i]) er++;
        chk(er == 1, "R7 one error pulse", er, 1);
        chk(cap_err[100] && cap_sop[100], "R7 error at restart byte",
            int'({cap_err[100], cap_sop[100]}), 3);
        chk(cap_eop[100 + PL - 1] && !cap_eop[PL - 1], "R7 eop after realign",
            int'({cap_eop[100 + PL - 1], cap_eop[PL - 1]}), 2);
        chk(cap_sop[100 + PL] && !cap_err[100 + PL], "R6 next start clean",
            int'({cap_sop[100 + PL], cap_err[100 + PL]}), 2);
        chk(cap_lock[100 + 2 * PL - 1] == 1'b0, "R8 run restarted by realign",
            int'(cap_lock[100 + 2 * PL - 1]), 0);

        // R9: lock loss after two bad packet starts
        start_run(1'b0, 1'b0, 1'b0);
        for (int p = 0; p < 3; p++) send_packet(8'h47, PL);
        send_packet(8'h00, PL);
        send_packet(8'h12, PL);
        repeat (30) @(negedge clk);
        chk(n_cap == 5 * PL, "R9 byte count", n_cap, 5 * PL);
        chk(cap_lock[3*PL] == 1'b1, "R9 lock held after one bad",
            int'(cap_lock[3*PL]), 1);
        chk(cap_lock[4*PL] == 1'b0, "R9 lock lost after two bad",
            int'(cap_lock[4*PL]), 0);

        // R10: reset mid-traffic clears lock
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!out_lock && !out_valid, "R10 reset clears lock",
            int'({out_lock, out_valid}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule